// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block computes one 32-bit result per cycle from two operands, an operation code and a 5-bit width field. Its operations all clamp the arithmetic to the representable range rather than wrapping: signed and unsigned add and subtract, a signed doubling, and saturation of a signed value to a chosen signed or unsigned bit width. The width saturation can treat the word as a whole or as two independent 16-bit halves. One variant of signed add only records overflow and returns the wrapped sum.

The result path is purely combinational, so `result` follows the inputs in the same cycle. A single sticky flag records that a result clamped. It is a register that is written on the clock edge only while `op_valid` is high, and it goes back to zero only through `flag_clr`. The datapath has no back-pressure: the caller presents operands and reads `result` in the same cycle. `op_valid` only qualifies the flag update and never stalls anything.

Top module: `sat_arith_unit`

## Requirements
- R1: Code 0 (signed add): if both operands share a sign and the sum's sign differs, the result is 0x7FFFFFFF when `opnd_a` is non-negative or 0x80000000 when it is negative, and the operation counts as clamping. Otherwise the result is the sum.
- R2: Code 1 (signed subtract a−b): if the operand signs differ and the difference's sign differs from `opnd_a`'s sign, the result clamps as in R1. Otherwise the result is the difference.
- R3: Code 2 (flag-only add): the result is always the wrapped sum a+b. A signed overflow by the rule of R1 still counts as clamping.
- R4: Code 3 (doubling of `opnd_a`): a signed input ≥ 0x40000000 gives 0x7FFFFFFF, and a signed input ≤ 0xC0000000 gives 0x80000000. Both count as clamping. Any other input gives `opnd_a` shifted left by one.
- R5: Code 4 (unsigned add) gives 0xFFFFFFFF when the sum exceeds 32 bits. Code 5 (unsigned subtract a−b) gives 0 when b > a. Either case counts as clamping.
- R6: Code 6 (signed width saturation of `opnd_a` to n=`width_sel`): let t = a >>> n. If t > 0 the result is 2^n−1. If t < −1 the result is ~(2^n−1). Either case counts as clamping. Otherwise `opnd_a` passes through.
- R7: Code 7 (unsigned width saturation): a negative `opnd_a` gives 0, and a value above 2^n−1 gives 2^n−1. Either case counts as clamping. Otherwise the value passes through.
- R8: Codes 8 and 9 apply the rules of R6 and R7 to bits [15:0] and [31:16] of `opnd_a` separately, each treated as a signed 16-bit value. The low 16 bits of each lane result are packed back into the same position. Clamping in either half counts.
- R9: Codes 10 to 15 give result 0 and never change the flag.
- R10: `sat_flag` is 0 after reset. On a clock edge with `op_valid` high and a clamping operation it becomes 1. With `op_valid` low, the edge leaves the flag unchanged.
- R11: Once set, `sat_flag` stays 1 until an edge with `flag_clr` high clears it. A clear wins over a clamp in the same cycle.
- R12: `result` is combinational and reflects the current inputs in the same cycle, regardless of `op_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Qualifies a flag update on this edge |
| op_code | input | 4 | Operation select (codes 0–9 defined) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| width_sel | input | 5 | Saturation width n for codes 6–9 |
| flag_clr | input | 1 | Clears the sticky flag on the edge |
| result | output | 32 | Combinational result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The checker watches several properties on every cycle. It checks that the flag only rises after a valid operation, that it holds until a clear, and that a clear empties it. It also checks that unused codes output zero, that non-negative signed addition never yields a negative result, and that unsigned add and subtract never move the result below or above `opnd_a` respectively. The exact clamp values, the boundary inputs of the doubling and width saturation, and the packing of the halfword lanes can only be shown by the bench's vectors. The same holds for the priority of a clear over a simultaneous clamp.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [3:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_SADDF  = 4'd2,
    OP_SDBL   = 4'd3,
    OP_UADD   = 4'd4,
    OP_USUB   = 4'd5,
    OP_SSATW  = 4'd6,
    OP_USATW  = 4'd7,
    OP_SSATH  = 4'd8,
    OP_USATH  = 4'd9
  } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          is_sub,
  input  logic          is_uns,
  input  logic          no_clamp,
  output logic [DW-1:0] res,
  output logic          clamp
);
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic [DW:0]   wide;
  logic [DW-1:0] raw;
  logic          s_ovf;
  logic          u_ovf;

  always_comb begin
    wide  = is_sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    raw   = wide[DW-1:0];
    u_ovf = wide[DW];
    if (is_sub)
      s_ovf = (a[DW-1] ^ b[DW-1]) & (raw[DW-1] ^ a[DW-1]);
    else
      s_ovf = ~(a[DW-1] ^ b[DW-1]) & (raw[DW-1] ^ a[DW-1]);

    res   = raw;
    clamp = 1'b0;
    if (is_uns) begin
      if (u_ovf) begin
        res   = is_sub ? '0 : '1;
        clamp = 1'b1;
      end
    end else if (s_ovf) begin
      clamp = 1'b1;
      if (!no_clamp) res = a[DW-1] ? SMIN : SMAX;
    end
  end
endmodule

// File: rtl/sat_double.sv
module sat_double #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  output logic [DW-1:0] res,
  output logic          clamp
);
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] HI_T = {2'b01, {(DW-2){1'b0}}};
  localparam logic [DW-1:0] LO_T = {2'b11, {(DW-2){1'b0}}};

  always_comb begin
    if ($signed(a) >= $signed(HI_T)) begin
      res   = SMAX;
      clamp = 1'b1;
    end else if ($signed(a) <= $signed(LO_T)) begin
      res   = SMIN;
      clamp = 1'b1;
    end else begin
      res   = a << 1;
      clamp = 1'b0;
    end
  end
endmodule

// File: rtl/sat_width_lane.sv
module sat_width_lane #(
  parameter int LW = 32,
  parameter int NW = 5
) (
  input  logic [LW-1:0] val,
  input  logic [NW-1:0] n,
  input  logic          is_uns,
  output logic [LW-1:0] res,
  output logic          clamp
);
  logic [LW-1:0]        lim;
  logic signed [LW-1:0] top;

  always_comb begin
    lim   = ({{(LW-1){1'b0}}, 1'b1} << n) - 1'b1;
    top   = $signed(val) >>> n;
    res   = val;
    clamp = 1'b0;
    if (is_uns) begin
      if (val[LW-1]) begin
        res   = '0;
        clamp = 1'b1;
      end else if (val > lim) begin
        res   = lim;
        clamp = 1'b1;
      end
    end else begin
      if (!top[LW-1] && (top != '0)) begin
        res   = lim;
        clamp = 1'b1;
      end else if (top[LW-1] && (top != '1)) begin
        res   = ~lim;
        clamp = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit #(
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [3:0]            op_code,
  input  logic [DW-1:0]         opnd_a,
  input  logic [DW-1:0]         opnd_b,
  input  logic [$clog2(DW)-1:0] width_sel,
  input  logic                  flag_clr,
  output logic [DW-1:0]         result,
  output logic                  sat_flag
);
  import sat_pkg::*;

  localparam int NW    = $clog2(DW);
  localparam int HW    = DW / 2;
  localparam int LANES = 2;

  logic [DW-1:0] as_res, dbl_res, wfull_res, half_res;
  logic          as_clamp, dbl_clamp, wfull_clamp;
  logic [LANES-1:0] half_clamp;
  logic          is_sub, is_uns, no_clamp, w_uns, h_uns;
  logic          clamp_now;

  assign is_sub   = (op_code == OP_SSUB) || (op_code == OP_USUB);
  assign is_uns   = (op_code == OP_UADD) || (op_code == OP_USUB);
  assign no_clamp = (op_code == OP_SADDF);
  assign w_uns    = (op_code == OP_USATW);
  assign h_uns    = (op_code == OP_USATH);

  sat_addsub #(.DW(DW)) u_addsub (
    .a(opnd_a), .b(opnd_b), .is_sub(is_sub), .is_uns(is_uns),
    .no_clamp(no_clamp), .res(as_res), .clamp(as_clamp)
  );

  sat_double #(.DW(DW)) u_double (
    .a(opnd_a), .res(dbl_res), .clamp(dbl_clamp)
  );

  sat_width_lane #(.LW(DW), .NW(NW)) u_wfull (
    .val(opnd_a), .n(width_sel), .is_uns(w_uns),
    .res(wfull_res), .clamp(wfull_clamp)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_half
    sat_width_lane #(.LW(HW), .NW(NW)) u_whalf (
      .val(opnd_a[g*HW +: HW]), .n(width_sel), .is_uns(h_uns),
      .res(half_res[g*HW +: HW]), .clamp(half_clamp[g])
    );
  end

  always_comb begin
    result    = '0;
    clamp_now = 1'b0;
    case (op_code)
      OP_SADD, OP_SSUB, OP_SADDF, OP_UADD, OP_USUB: begin
        result    = as_res;
        clamp_now = as_clamp;
      end
      OP_SDBL: begin
        result    = dbl_res;
        clamp_now = dbl_clamp;
      end
      OP_SSATW, OP_USATW: begin
        result    = wfull_res;
        clamp_now = wfull_clamp;
      end
      OP_SSATH, OP_USATH: begin
        result    = half_res;
        clamp_now = |half_clamp;
      end
      default: begin
        result    = '0;
        clamp_now = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sat_flag <= 1'b0;
    else if (flag_clr)
      sat_flag <= 1'b0;
    else if (op_valid && clamp_now)
      sat_flag <= 1'b1;
  end
endmodule

// File: rtl/sat_arith_chk.sv
module sat_arith_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [3:0]    op_code,
  input logic [DW-1:0] opnd_a,
  input logic [DW-1:0] opnd_b,
  input logic          flag_clr,
  input logic [DW-1:0] result,
  input logic          sat_flag
);
  // R10
  flag_rise_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> $past(op_valid) && !$past(flag_clr));

  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !sat_flag);

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !flag_clr) |=> sat_flag);

  // R9
  unused_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code >= 4'd10) |-> (result == '0));

  // R9
  unused_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code >= 4'd10 && !flag_clr) |=> $stable(sat_flag));

  // R1
  pos_add_no_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd0 && !opnd_a[DW-1] && !opnd_b[DW-1]) |-> !result[DW-1]);

  // R5
  uadd_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd4) |-> (result >= opnd_a));

  // R5
  usub_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd5) |-> (result <= opnd_a));
endmodule

bind sat_arith_unit sat_arith_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_clr(flag_clr),
  .result(result), .sat_flag(sat_flag)
);

// File: tb/sat_arith_unit_bench.sv
`timescale 1ns/1ps
module sat_arith_unit_bench;
  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  w;
    logic [31:0] exp;
    logic        cl;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 32'h00000001, 32'h00000002, 5'd0, 32'h00000003, 1'b0}, // R1
    '{4'd0, 32'h7FFFFFFF, 32'h00000001, 5'd0, 32'h7FFFFFFF, 1'b1}, // R1
    '{4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0, 32'h80000000, 1'b1}, // R1
    '{4'd1, 32'h80000000, 32'h00000001, 5'd0, 32'h80000000, 1'b1}, // R2
    '{4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 32'h7FFFFFFF, 1'b1}, // R2
    '{4'd1, 32'h00000005, 32'h00000003, 5'd0, 32'h00000002, 1'b0}, // R2
    '{4'd2, 32'h7FFFFFFF, 32'h00000001, 5'd0, 32'h80000000, 1'b1}, // R3
    '{4'd3, 32'h40000000, 32'h00000000, 5'd0, 32'h7FFFFFFF, 1'b1}, // R4
    '{4'd3, 32'hC0000000, 32'h00000000, 5'd0, 32'h80000000, 1'b1}, // R4
    '{4'd3, 32'h3FFFFFFF, 32'h00000000, 5'd0, 32'h7FFFFFFE, 1'b0}, // R4
    '{4'd3, 32'hC0000001, 32'h00000000, 5'd0, 32'h80000002, 1'b0}, // R4
    '{4'd4, 32'hFFFFFFFF, 32'h00000001, 5'd0, 32'hFFFFFFFF, 1'b1}, // R5
    '{4'd4, 32'h00000010, 32'h00000020, 5'd0, 32'h00000030, 1'b0}, // R5
    '{4'd5, 32'h00000001, 32'h00000002, 5'd0, 32'h00000000, 1'b1}, // R5
    '{4'd5, 32'h00000005, 32'h00000005, 5'd0, 32'h00000000, 1'b0}, // R5
    '{4'd6, 32'h00000100, 32'h00000000, 5'd7, 32'h0000007F, 1'b1}, // R6
    '{4'd6, 32'hFFFFFF00, 32'h00000000, 5'd7, 32'hFFFFFF80, 1'b1}, // R6
    '{4'd6, 32'hFFFFFF80, 32'h00000000, 5'd7, 32'hFFFFFF80, 1'b0}, // R6
    '{4'd6, 32'h7FFFFFFF, 32'h00000000, 5'd31, 32'h7FFFFFFF, 1'b0}, // R6
    '{4'd7, 32'hFFFFFFFF, 32'h00000000, 5'd8, 32'h00000000, 1'b1}, // R7
    '{4'd7, 32'h00000100, 32'h00000000, 5'd8, 32'h000000FF, 1'b1}, // R7
    '{4'd7, 32'h000000FF, 32'h00000000, 5'd8, 32'h000000FF, 1'b0}, // R7
    '{4'd8, 32'h0200FE00, 32'h00000000, 5'd7, 32'h007FFF80, 1'b1}, // R8
    '{4'd8, 32'h0005FFFB, 32'h00000000, 5'd7, 32'h0005FFFB, 1'b0}, // R8
    '{4'd9, 32'h80000100, 32'h00000000, 5'd8, 32'h000000FF, 1'b1}, // R8
    '{4'd15, 32'h00000123, 32'h7FFFFFFF, 5'd3, 32'h00000000, 1'b0} // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [4:0]  width_sel = '0;
  logic        flag_clr = 1'b0;
  logic [31:0] result;
  logic        sat_flag;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sat_arith_unit u_sat_arith_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .width_sel(width_sel),
    .flag_clr(flag_clr), .result(result), .sat_flag(sat_flag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk);
    op_valid = 1'b0;
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] w, input logic v);
    op_code = op; opnd_a = a; opnd_b = b; width_sel = w; op_valid = v;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 flag after reset", {31'd0, sat_flag}, 32'd0);
    apply(4'd0, 32'd0, 32'd0, 5'd0, 1'b0);
    check("R12 reset-time result", result, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      clear_flag();
      apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].w, 1'b1);
      check($sformatf("R12 vector %0d result op=%0d", i, VECS[i].op), result, VECS[i].exp);
      @(negedge clk);
      op_valid = 1'b0;
      check($sformatf("R10 vector %0d flag op=%0d", i, VECS[i].op), {31'd0, sat_flag}, {31'd0, VECS[i].cl});
    end

    // R10: clamp with op_valid low leaves flag clear, result still clamped (R12)
    clear_flag();
    apply(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b0);
    check("R12 result without valid", result, 32'h7FFFFFFF);
    @(negedge clk);
    check("R10 no set without valid", {31'd0, sat_flag}, 32'd0);

    // R11: sticky across non-clamping ops
    apply(4'd4, 32'hFFFFFFFF, 32'h2, 5'd0, 1'b1);
    @(negedge clk);
    apply(4'd4, 32'h1, 32'h2, 5'd0, 1'b1);
    @(negedge clk);
    apply(4'd6, 32'h5, 32'h0, 5'd4, 1'b1);
    @(negedge clk);
    op_valid = 1'b0;
    check("R11 flag sticky", {31'd0, sat_flag}, 32'd1);

    // R9: unused code with flag set leaves it set
    apply(4'd12, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0, 1'b1);
    check("R9 unused code result", result, 32'd0);
    @(negedge clk);
    op_valid = 1'b0;
    check("R9 unused code keeps flag", {31'd0, sat_flag}, 32'd1);

    // R11: clear beats simultaneous clamp
    apply(4'd5, 32'h0, 32'h1, 5'd0, 1'b1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    op_valid = 1'b0;
    check("R11 clear wins", {31'd0, sat_flag}, 32'd0);

    // R3: flag-only add without overflow leaves flag clear
    apply(4'd2, 32'h80000000, 32'h7FFFFFFF, 5'd0, 1'b1);
    check("R3 no overflow sum", result, 32'hFFFFFFFF);
    @(negedge clk);
    op_valid = 1'b0;
    check("R3 no overflow flag", {31'd0, sat_flag}, 32'd0);

    // R8: unsigned halfword lane pass-through
    apply(4'd9, 32'h0012_0034, 32'h0, 5'd8, 1'b0);
    check("R8 usat16 pass", result, 32'h0012_0034);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule